// File: doc/BRIEF.md
# Custom-Instruction Stall Timer

This unit sits on a processor's custom-instruction port and implements one extension instruction: a timed pipeline hold. When the instruction's function code matches the stall code while the unit is idle, the unit loads a cycle count from the low bits of the first register operand. It then drives a registered stall output to the core for exactly that many clock cycles. The core clock keeps running during the hold. The stall ends on its own when the count runs out, and only that or a hard reset can end it.

When the hold ends, the unit returns a zero result with a one-cycle valid strobe, and the core picks the result up as the instruction retires. A count of zero produces no stall and returns the result on the next cycle. Other function codes, and stall instructions that arrive while a hold is in progress, are not acted on.

Top module: `cxs_stall_timer`

## Requirements
- R1: When `insn_valid` is high at a rising edge with `insn_func` equal to STALL_FUNC (default 5'h1A), `busy` low, and a nonzero count N in `src_a[CNT_W-1:0]`, then `stall` is high for exactly N consecutive cycles, starting the cycle after that edge.
- R2: A stall instruction with a zero count never raises `stall`, and `result_valid` is high in the cycle after the accepting edge.
- R3: Instructions with any other function code never raise `stall` or `result_valid`.
- R4: A stall instruction presented while `busy` is high is ignored. The hold in progress keeps its original length, and no extra hold or result follows.
- R5: `result_valid` is high for one cycle, in the first cycle after `stall` falls, and `result` is zero whenever `result_valid` is high.
- R6: `busy` is high exactly while `stall` is high.
- R7: While `rst_n` is low, `stall`, `busy` and `result_valid` are low. Asserting `rst_n` ends a hold at once, without waiting for a clock edge.
- R8: Only `src_a[CNT_W-1:0]` (default 16 bits) sets the count. Higher bits of `src_a` and all of `src_b` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| insn_valid | input | 1 | Custom instruction present in execute |
| insn_func | input | FUNC_W | Function field of the custom instruction |
| src_a | input | DATA_W | First register operand; its low CNT_W bits are the cycle count |
| src_b | input | DATA_W | Second register operand, unused by the stall code |
| result | output | DATA_W | Destination result, zero for the stall code |
| result_valid | output | 1 | One-cycle strobe marking the result as valid |
| stall | output | 1 | Registered pipeline hold to the core |
| busy | output | 1 | A hold is in progress |

## Verification
The bench measures each hold length against the count for random counts, for zero, and for an operand whose upper bits are set. A design that decodes too many bits, or that is off by one in the counter, returns a wrong length. It sends a second stall while a hold is running. A design that reloads on that instruction stretches or shortens the hold, or gives two result strobes. It also pulls reset in the middle of a long hold and checks that the stall drops at once. Foreign function codes are checked so that a loose decoder, which would stall the core on an unrelated instruction, is caught.

// File: rtl/cxs_stall_pkg.sv
package cxs_stall_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned FUNC_W     = 5;
  localparam int unsigned CNT_W      = 16;
  localparam logic [FUNC_W-1:0] STALL_FUNC = 5'h1A;

  typedef struct packed {
    logic            hit;
    logic            zero;
    logic [CNT_W-1:0] count;
  } stall_req_t;
endpackage

// File: rtl/cxs_stall_decode.sv
module cxs_stall_decode #(
  parameter int unsigned DATA_W = cxs_stall_pkg::DATA_W,
  parameter int unsigned FUNC_W = cxs_stall_pkg::FUNC_W,
  parameter int unsigned CNT_W  = cxs_stall_pkg::CNT_W,
  parameter logic [FUNC_W-1:0] STALL_FUNC = cxs_stall_pkg::STALL_FUNC
) (
  input  logic              insn_valid,
  input  logic [FUNC_W-1:0] insn_func,
  input  logic [DATA_W-1:0] src_a,
  output cxs_stall_pkg::stall_req_t req
);
  // The count field is the low CNT_W bits of the first operand.
  always_comb begin
    req.hit   = insn_valid && (insn_func == STALL_FUNC);
    req.count = src_a[CNT_W-1:0];
    req.zero  = (src_a[CNT_W-1:0] == '0);
  end
endmodule

// File: rtl/cxs_stall_counter.sv
module cxs_stall_counter #(
  parameter int unsigned CNT_W = cxs_stall_pkg::CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  cxs_stall_pkg::stall_req_t req,
  output logic stall_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stall_q, stall_d;
  logic             done_q, done_d;
  logic             accept, last, cnt_en;

  // Requests are taken only while idle; a request during a hold is dropped.
  assign accept = req.hit && !stall_q;
  assign last   = stall_q && (cnt_q == CNT_W'(1));
  assign cnt_en = accept || stall_q;

  always_comb begin
    cnt_d   = cnt_q;
    stall_d = stall_q;
    if (accept && !req.zero) begin
      cnt_d   = req.count;
      stall_d = 1'b1;
    end else if (stall_q) begin
      cnt_d   = cnt_q - CNT_W'(1);
      stall_d = !last;
    end
    done_d = last || (accept && req.zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stall_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q   <= cnt_d;
        stall_q <= stall_d;
      end
      done_q <= done_d;
    end
  end

  assign stall_o = stall_q;
  assign done_o  = done_q;
endmodule

// File: rtl/cxs_stall_timer.sv
module cxs_stall_timer #(
  parameter int unsigned DATA_W = cxs_stall_pkg::DATA_W,
  parameter int unsigned FUNC_W = cxs_stall_pkg::FUNC_W,
  parameter int unsigned CNT_W  = cxs_stall_pkg::CNT_W,
  parameter logic [FUNC_W-1:0] STALL_FUNC = cxs_stall_pkg::STALL_FUNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [FUNC_W-1:0] insn_func,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              stall,
  output logic              busy
);
  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0]          rst_sync_q;
  logic                       rst_int_n;
  cxs_stall_pkg::stall_req_t  req;
  logic                       stall_w, done_w;
  logic                       unused_b;

  // Reset asserts asynchronously and is released through a short flop chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  cxs_stall_decode #(
    .DATA_W(DATA_W), .FUNC_W(FUNC_W), .CNT_W(CNT_W), .STALL_FUNC(STALL_FUNC)
  ) u_dec (
    .insn_valid(insn_valid),
    .insn_func (insn_func),
    .src_a     (src_a),
    .req       (req)
  );

  cxs_stall_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .req    (req),
    .stall_o(stall_w),
    .done_o (done_w)
  );

  assign unused_b     = ^src_b;
  assign stall        = stall_w;
  assign busy         = stall_w;
  assign result_valid = done_w;
  assign result       = '0;
endmodule

// File: rtl/cxs_stall_timer_chk.sv
module cxs_stall_timer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FUNC_W = 5,
  parameter int unsigned CNT_W  = 16,
  parameter logic [FUNC_W-1:0] STALL_FUNC = 5'h1A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_valid,
  input logic [FUNC_W-1:0] insn_func,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] result,
  input logic              result_valid,
  input logic              stall,
  input logic              busy
);
  logic go_nz, go_z, is_stall_op;
  assign is_stall_op = insn_valid && (insn_func == STALL_FUNC);
  assign go_nz = is_stall_op && !busy && (src_a[CNT_W-1:0] != '0);
  assign go_z  = is_stall_op && !busy && (src_a[CNT_W-1:0] == '0);

  // R1
  a_r1_stall_starts: assert property (@(posedge clk) disable iff (!rst_n)
    go_nz |=> stall);
  // R2
  a_r2_zero_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    go_z |=> (!stall && result_valid));
  // R3
  a_r3_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !is_stall_op) |=> (!stall && !result_valid));
  // R5
  a_r5_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> result_valid);
  a_r5_result_zero: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (result == '0));
  a_r5_no_valid_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !result_valid);
  // R4
  a_r4_hold_not_reloaded: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && is_stall_op) |=> !result_valid || !stall);
endmodule

bind cxs_stall_timer cxs_stall_timer_chk #(
  .DATA_W(DATA_W), .FUNC_W(FUNC_W), .CNT_W(CNT_W), .STALL_FUNC(STALL_FUNC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_func(insn_func),
  .src_a(src_a), .result(result), .result_valid(result_valid),
  .stall(stall), .busy(busy)
);

// File: tb/sim_cxs_stall_timer.sv
`timescale 1ns/1ps
module sim_cxs_stall_timer;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FUNC_W = 5;
  localparam int unsigned CNT_W  = 16;
  localparam logic [FUNC_W-1:0] SF = 5'h1A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_valid = 1'b0;
  logic [FUNC_W-1:0] insn_func = '0;
  logic [DATA_W-1:0] src_a = '0, src_b = '0;
  logic [DATA_W-1:0] result;
  logic result_valid, stall, busy;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cxs_stall_timer u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_func(insn_func),
    .src_a(src_a), .src_b(src_b), .result(result), .result_valid(result_valid),
    .stall(stall), .busy(busy)
  );

  function automatic int exp_len(input logic [FUNC_W-1:0] f, input logic [DATA_W-1:0] a);
    return (f == SF) ? int'(a[CNT_W-1:0]) : 0;
  endfunction

  function automatic bit exp_valid(input logic [FUNC_W-1:0] f);
    return f == SF;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one instruction, measure the hold length, and sample the result strobe.
  task automatic issue(input logic [FUNC_W-1:0] f, input logic [DATA_W-1:0] a,
                       input logic [DATA_W-1:0] b, input string req);
    int len;
    @(negedge clk);
    insn_valid = 1'b1; insn_func = f; src_a = a; src_b = b;
    @(negedge clk);
    insn_valid = 1'b0; insn_func = '0;
    len = 0;
    while (stall && len < 70000) begin
      if (busy !== 1'b1) chk("R6 busy during hold", busy, 1);
      if (result_valid !== 1'b0) chk("R5 valid during hold", result_valid, 0);
      len++;
      @(negedge clk);
    end
    chk({req, " hold length"}, len, exp_len(f, a));
    chk({req, " R5 result_valid"}, result_valid, exp_valid(f));
    chk("R6 busy after hold", busy, 0);
    if (result_valid) chk("R5 result zero", result, 0);
    @(negedge clk);
    chk("R5 strobe one cycle", result_valid, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R7 stall in reset", stall, 0);
    chk("R7 busy in reset", busy, 0);
    chk("R7 valid in reset", result_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    issue(SF, 32'd5, 32'd0, "R1");
    issue(SF, 32'd1, 32'd0, "R1 min");
    issue(SF, 32'd0, 32'd7, "R2");
    issue(5'h1B, 32'd9, 32'd0, "R3");
    issue(5'h0A, 32'd4, 32'd0, "R3");
    issue(SF, 32'h0001_0004, 32'hFFFF_FFFF, "R8");
    issue(SF, 32'hFFFF_0000, 32'd3, "R8 high bits only");

    // R4: a second stall during a hold must not change it.
    begin
      int len;
      @(negedge clk);
      insn_valid = 1'b1; insn_func = SF; src_a = 32'd6;
      @(negedge clk);
      insn_valid = 1'b0;
      len = 1;
      @(negedge clk);
      insn_valid = 1'b1; src_a = 32'd20;
      len++;
      @(negedge clk);
      insn_valid = 1'b0;
      while (stall && len < 100) begin len++; @(negedge clk); end
      chk("R4 hold length unchanged", len, 6);
      chk("R4 single result", result_valid, 1);
      repeat (25) begin
        @(negedge clk);
        if (stall || result_valid) chk("R4 no second hold", {stall, result_valid}, 0);
      end
    end

    // Random mix of codes and counts.
    for (int i = 0; i < 40; i++) begin
      logic [FUNC_W-1:0] f;
      logic [DATA_W-1:0] a;
      f = ($urandom % 3 == 0) ? FUNC_W'($urandom) : SF;
      a = ($urandom % 40) | (DATA_W'($urandom % 4) << CNT_W);
      issue(f, a, $urandom, (f == SF) ? "R1 random" : "R3 random");
    end

    // R7: reset in the middle of a long hold drops stall at once.
    @(negedge clk);
    insn_valid = 1'b1; insn_func = SF; src_a = 32'd500;
    @(negedge clk);
    insn_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 hold running", stall, 1);
    #1 rst_n = 1'b0;
    #1;
    chk("R7 async stall drop", stall, 0);
    chk("R7 async busy drop", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 idle after reset", stall, 0);
    issue(SF, 32'd3, 32'd0, "R1 after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule